// File: doc/BRIEF.md
# Word-Serial Radix-2 Montgomery Multiplier

This block multiplies two residues modulo an odd modulus M and returns S ≡ X·Y·2^(−N) (mod M). It is meant as the arithmetic core of a modular-arithmetic engine that keeps all of its values in Montgomery residue form, so squaring is the same operation with X = Y. The block steps through the bits of X one at a time, lowest first. For each bit it walks the words of Y, M and the running partial result S, one word per clock, through a word-wide adder pair that keeps two separate carries.

The operands stay outside the block. The block publishes a bit index for X and a word index for Y and M, and the surrounding logic returns the addressed bit and words in the same cycle. The result is held in an internal word store after completion. It is read through an asynchronous word read port. No final conditional subtraction is made. The caller keeps 4M < 2^N, and operands and results then stay below 2M, so a result can feed the next multiplication directly.

Top module: `mont_mul_r2`

## Requirements
- R1: After reset, `busy` and `done` are 0 and every result word reads as 0.
- R2: For odd M with 4M < 2^N and X, Y < 2M, the result satisfies S·2^N ≡ X·Y (mod M). S is the concatenation of the words at result addresses 0 through NW−1, address 0 holding the least significant W bits, with NW = ceil((N+1)/W).
- R3: Under the same input bounds, the result is below 2M, with no final subtraction.
- R4: `done` rises exactly N·NW clock cycles after the clock edge that accepts `start`, whatever the operand values. `busy` is high for those cycles.
- R5: `done` stays high and the result words stay unchanged until the next accepted `start`.
- R6: A `start` pulse while `busy` is high is ignored. Both the result and the completion time of the running operation are unaffected.
- R7: If X = 0 or Y = 0, the result is exactly 0.
- R8: Squaring (X = Y) is computed by the same path and meets R2 and R3.
- R9: A read address at or above NW returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a multiplication (accepted only when idle) |
| x_idx | output | XIW = $clog2(N) | Index of the X bit requested this cycle |
| x_bit | input | 1 | Bit x_idx of X |
| w_idx | output | WIW = $clog2(NW) | Index of the Y and M word requested this cycle |
| y_word | input | W | Word w_idx of Y |
| m_word | input | W | Word w_idx of M |
| s_raddr | input | WIW | Result word read address |
| s_rdata | output | W | Result word at s_raddr (0 when out of range) |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | Result valid, held until the next accepted start |

## Verification
The embedded checks on the datapath take the caller's side of the contract as given: M is odd, 4M < 2^N, and both operands are below 2M. Only then is every row sum even, and only then does no carry leave the top word. These assumptions hold for the whole operation, because the bit and word lookups return the same operands from start to done. The stimulus keeps to them by construction. Table moduli are odd constants below 2^(N−2). Random moduli are masked to N−2 bits with bit 0 forced to 1. Random operands are reduced modulo 2M before use, and the edge rows use M = 1, M = 3 and M = 2^(N−2)−1 with operands at 2M−1.

// File: rtl/mont_mul_pkg.sv
package mont_mul_pkg;

   typedef enum logic {
      MM_IDLE = 1'b0,
      MM_RUN  = 1'b1
   } mm_state_e;

   // words needed to hold an (n+1)-bit value: one guard bit above the modulus width
   function automatic int mm_word_count(input int n, input int w);
      return (n + w) / w;
   endfunction

endpackage

// File: rtl/mm_seq.sv
module mm_seq
   import mont_mul_pkg::*;
#(
   parameter int N   = 198,
   parameter int NW  = 7,
   parameter int XIW = 8,
   parameter int WIW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   output logic           launch,
   output logic           busy,
   output logic           done,
   output logic           first,
   output logic           last,
   output logic [XIW-1:0] bit_idx,
   output logic [WIW-1:0] word_idx
);

   localparam logic [XIW-1:0] BIT_LAST  = XIW'(N - 1);
   localparam logic [WIW-1:0] WORD_LAST = WIW'(NW - 1);
   localparam int             LATENCY   = N * NW;

   mm_state_e state;
   logic      op_final;

   assign busy     = (state == MM_RUN);
   assign launch   = start & ~busy;
   assign first    = busy & (word_idx == '0);
   assign last     = busy & (word_idx == WORD_LAST);
   assign op_final = last & (bit_idx == BIT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= MM_IDLE;
         done     <= 1'b0;
         bit_idx  <= '0;
         word_idx <= '0;
      end else if (launch) begin
         state    <= MM_RUN;
         done     <= 1'b0;
         bit_idx  <= '0;
         word_idx <= '0;
      end else if (busy) begin
         if (last) begin
            word_idx <= '0;
            if (op_final) begin
               state <= MM_IDLE;
               done  <= 1'b1;
            end else begin
               bit_idx <= bit_idx + 1'b1;
            end
         end else begin
            word_idx <= word_idx + 1'b1;
         end
      end
   end

   // cycle counter used only by the latency check below
   logic [31:0] lat_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lat_cnt <= '0;
      else if (launch) lat_cnt <= '0;
      else if (busy)   lat_cnt <= lat_cnt + 32'd1;
   end

   assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (32'(word_idx) < NW) && (32'(bit_idx) < N));

   assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (lat_cnt == 32'(LATENCY)));

   assert_done_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !last) |=>
         (busy && bit_idx == $past(bit_idx) && word_idx == $past(word_idx) + 1'b1));

endmodule

// File: rtl/mm_word_pe.sv
module mm_word_pe #(
   parameter int W        = 32,
   parameter bit FA_CHAIN = 1'b0
) (
   input  logic         x_bit,
   input  logic         q,
   input  logic [W-1:0] y,
   input  logic [W-1:0] m,
   input  logic [W-1:0] s_old,
   input  logic         ca_i,
   input  logic         cb_i,
   output logic [W-1:0] u,
   output logic         ca_o,
   output logic         cb_o
);

   logic [W-1:0] ya;
   logic [W-1:0] ma;
   logic [W-1:0] t;

   assign ya = x_bit ? y : '0;
   assign ma = q     ? m : '0;

   if (FA_CHAIN) begin : g_ripple
      logic [W:0] ka;
      logic [W:0] kb;
      assign ka[0] = ca_i;
      assign kb[0] = cb_i;
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign t[b]    = ya[b] ^ ma[b] ^ ka[b];
         assign ka[b+1] = (ya[b] & ma[b]) | (ka[b] & (ya[b] ^ ma[b]));
         assign u[b]    = t[b] ^ s_old[b] ^ kb[b];
         assign kb[b+1] = (t[b] & s_old[b]) | (kb[b] & (t[b] ^ s_old[b]));
      end
      assign ca_o = ka[W];
      assign cb_o = kb[W];
   end else begin : g_behav
      assign {ca_o, t} = {1'b0, ya} + {1'b0, ma} + {{W{1'b0}}, ca_i};
      assign {cb_o, u} = {1'b0, t} + {1'b0, s_old} + {{W{1'b0}}, cb_i};
   end

endmodule

// File: rtl/mm_sreg.sv
module mm_sreg #(
   parameter int W   = 32,
   parameter int NW  = 7,
   parameter int WIW = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           we,
   input  logic           first,
   input  logic           last,
   input  logic [WIW-1:0] widx,
   input  logic [W-1:0]   u,
   output logic [W-1:0]   rd_cur,
   input  logic [WIW-1:0] raddr,
   output logic [W-1:0]   rdata
);

   logic [W-1:0] mem [NW];
   logic [W-2:0] u_hi;

   assign rd_cur = mem[widx];
   assign rdata  = (32'(raddr) < NW) ? mem[raddr] : '0;

   // word j-1 receives its top bit from bit 0 of word j: a right shift across words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NW; k++) mem[k] <= '0;
         u_hi <= '0;
      end else if (clr) begin
         for (int k = 0; k < NW; k++) mem[k] <= '0;
         u_hi <= '0;
      end else if (we) begin
         u_hi <= u[W-1:1];
         if (!first) mem[widx - 1'b1] <= {u[0], u_hi};
         if (last)   mem[widx]        <= {1'b0, u[W-1:1]};
      end
   end

endmodule

// File: rtl/mont_mul_r2.sv
module mont_mul_r2
   import mont_mul_pkg::*;
#(
   parameter int  N        = 198,
   parameter int  W        = 32,
   parameter bit  FA_CHAIN = 1'b0,
   localparam int NW       = mm_word_count(N, W),
   localparam int XIW      = $clog2(N),
   localparam int WIW      = $clog2(NW)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   output logic [XIW-1:0] x_idx,
   input  logic           x_bit,
   output logic [WIW-1:0] w_idx,
   input  logic [W-1:0]   y_word,
   input  logic [W-1:0]   m_word,
   input  logic [WIW-1:0] s_raddr,
   output logic [W-1:0]   s_rdata,
   output logic           busy,
   output logic           done
);

   if (W < 4) begin : g_bad_w
      $error("mont_mul_r2: word width W must be at least 4");
   end
   if (N < 3) begin : g_bad_n
      $error("mont_mul_r2: operand width N must be at least 3");
   end
   if (NW < 2) begin : g_bad_nw
      $error("mont_mul_r2: N+1 must span at least two words");
   end

   logic           launch;
   logic           first;
   logic           last;
   logic [W-1:0]   s_cur;
   logic [W-1:0]   u;
   logic           ca_o;
   logic           cb_o;
   logic           ca_r;
   logic           cb_r;
   logic           q0;
   logic           q_r;
   logic           q_use;

   mm_seq #(.N(N), .NW(NW), .XIW(XIW), .WIW(WIW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .launch   (launch),
      .busy     (busy),
      .done     (done),
      .first    (first),
      .last     (last),
      .bit_idx  (x_idx),
      .word_idx (w_idx)
   );

   // quotient bit from bit logic only, taken on word 0 and held for the row
   assign q0    = (x_bit & y_word[0]) ^ s_cur[0];
   assign q_use = first ? q0 : q_r;

   mm_word_pe #(.W(W), .FA_CHAIN(FA_CHAIN)) u_pe (
      .x_bit (x_bit),
      .q     (q_use),
      .y     (y_word),
      .m     (m_word),
      .s_old (s_cur),
      .ca_i  (ca_r),
      .cb_i  (cb_r),
      .u     (u),
      .ca_o  (ca_o),
      .cb_o  (cb_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ca_r <= 1'b0;
         cb_r <= 1'b0;
         q_r  <= 1'b0;
      end else if (launch) begin
         ca_r <= 1'b0;
         cb_r <= 1'b0;
         q_r  <= 1'b0;
      end else if (busy) begin
         if (first) q_r <= q0;
         if (last) begin
            ca_r <= 1'b0;
            cb_r <= 1'b0;
         end else begin
            ca_r <= ca_o;
            cb_r <= cb_o;
         end
      end
   end

   mm_sreg #(.W(W), .NW(NW), .WIW(WIW)) u_sreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (launch),
      .we     (busy),
      .first  (first),
      .last   (last),
      .widx   (w_idx),
      .u      (u),
      .rd_cur (s_cur),
      .raddr  (s_raddr),
      .rdata  (s_rdata)
   );

   // the quotient must make every row sum even, so nothing is lost in the shift
   assert_even_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && first) |-> (u[0] == 1'b0));

   // with 4M < 2^N and operands below 2M the row sum fits the word store
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && last) |-> (!ca_o && !cb_o));

endmodule

// File: tb/mont_mul_r2_bench.sv
`timescale 1ns/1ps
module mont_mul_r2_bench;

   localparam int N    = 198;
   localparam int W    = 32;
   localparam int NW   = (N + W) / W;
   localparam int XIW  = $clog2(N);
   localparam int WIW  = $clog2(NW);
   localparam int LAT  = N * NW;
   localparam int NVEC = 5;

   localparam logic [N-1:0] MBIG = {2'b00, {(N-2){1'b1}}};
   localparam logic [N-1:0] XBIG = MBIG * 2 - 1;
   localparam logic [N-1:0] M0 = N'(192'hC3A5_9E21_7F04_B6D8_1A2B_3C4D_5E6F_7081_92A3_B4C5_D6E7_F809);
   localparam logic [N-1:0] X0 = N'(192'h9F1E_2D3C_4B5A_6978_8796_A5B4_C3D2_E1F0_0F1E_2D3C_4B5A_6979);
   localparam logic [N-1:0] Y0 = N'(192'h1234_5678_9ABC_DEF0_1357_9BDF_2468_ACE0_FDB9_7531_ECA8_6420);

   // columns: X, Y, M ; row 4 is a squaring
   localparam logic [N-1:0] TBL [NVEC][3] = '{
      '{X0,            Y0,            M0},
      '{N'(5),         N'(4),         N'(3)},
      '{XBIG,          XBIG,          MBIG},
      '{N'(1),         N'(1),         N'(1)},
      '{Y0,            Y0,            M0}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [XIW-1:0] x_idx;
   logic           x_bit;
   logic [WIW-1:0] w_idx;
   logic [W-1:0]   y_word;
   logic [W-1:0]   m_word;
   logic [WIW-1:0] s_raddr = '0;
   logic [W-1:0]   s_rdata;
   logic           busy;
   logic           done;

   logic [N-1:0]    xv = '0;
   logic [N-1:0]    yv = '0;
   logic [N-1:0]    mv = '0;
   logic [NW*W-1:0] yv_ext;
   logic [NW*W-1:0] mv_ext;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   assign yv_ext = (NW*W)'(yv);
   assign mv_ext = (NW*W)'(mv);
   assign x_bit  = xv[x_idx];
   assign y_word = yv_ext[w_idx*W +: W];
   assign m_word = mv_ext[w_idx*W +: W];

   mont_mul_r2 #(.N(N), .W(W)) u_mont_mul_r2 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .x_idx   (x_idx),
      .x_bit   (x_bit),
      .w_idx   (w_idx),
      .y_word  (y_word),
      .m_word  (m_word),
      .s_raddr (s_raddr),
      .s_rdata (s_rdata),
      .busy    (busy),
      .done    (done)
   );

   task automatic check(input bit ok, input string req, input logic [511:0] act,
                        input logic [511:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NW*W-1:0] rnd_wide();
      logic [NW*W-1:0] r;
      for (int k = 0; k < NW; k++) r[k*W +: W] = W'($urandom);
      return r;
   endfunction

   task automatic read_s(output logic [NW*W-1:0] s);
      for (int a = 0; a < NW; a++) begin
         s_raddr = WIW'(a);
         #0.2;
         s[a*W +: W] = s_rdata;
      end
   endtask

   // poke > 0: extra start pulse that many cycles into the run
   task automatic run_mul(input logic [N-1:0] x, input logic [N-1:0] y,
                          input logic [N-1:0] m, input int poke,
                          output logic [NW*W-1:0] s);
      int cyc;
      xv = x; yv = y; mv = m;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cyc = 0;
      while (!done && cyc < LAT + 20) begin
         @(negedge clk);
         cyc++;
         start = (poke > 0 && cyc == poke);
      end
      start = 1'b0;
      check(cyc == LAT, "R4 latency", 512'(cyc), 512'(LAT));
      read_s(s);
   endtask

   function automatic bit cong_ok(input logic [NW*W-1:0] s, input logic [N-1:0] x,
                                  input logic [N-1:0] y, input logic [N-1:0] m);
      logic [511:0] lhs;
      logic [511:0] rhs;
      lhs = (512'(s) << N) % 512'(m);
      rhs = (512'(x) * 512'(y)) % 512'(m);
      return lhs == rhs;
   endfunction

   initial begin
      logic [NW*W-1:0] s;
      logic [NW*W-1:0] s2;
      logic [NW*W-1:0] r;
      logic [511:0]    t;
      logic [N-1:0]    rx;
      logic [N-1:0]    ry;
      logic [N-1:0]    rm;

      repeat (4) @(negedge clk);
      // R1: reset state
      check(busy == 1'b0, "R1 busy", 512'(busy), 512'(0));
      check(done == 1'b0, "R1 done", 512'(done), 512'(0));
      read_s(s);
      check(s == '0, "R1 result", 512'(s), 512'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: R2 congruence, R3 bound, R8 on the squaring row
      for (int v = 0; v < NVEC; v++) begin
         run_mul(TBL[v][0], TBL[v][1], TBL[v][2], 0, s);
         check(cong_ok(s, TBL[v][0], TBL[v][1], TBL[v][2]), (v == 4) ? "R8 square" : "R2 table",
               512'(s), 512'(TBL[v][2]));
         check(512'(s) < 2 * 512'(TBL[v][2]), "R3 table bound", 512'(s), 2 * 512'(TBL[v][2]));
      end

      // random odd moduli with 4M < 2^N, operands below 2M
      for (int k = 0; k < 10; k++) begin
         r  = rnd_wide();
         rm = r[N-1:0] & MBIG;
         rm[0] = 1'b1;
         t  = 512'(rnd_wide()) % (2 * 512'(rm));
         rx = t[N-1:0];
         t  = 512'(rnd_wide()) % (2 * 512'(rm));
         ry = t[N-1:0];
         run_mul(rx, ry, rm, 0, s);
         check(cong_ok(s, rx, ry, rm), "R2 random", 512'(s), 512'(rm));
         check(512'(s) < 2 * 512'(rm), "R3 random bound", 512'(s), 2 * 512'(rm));
      end

      // R7: zero operands give exactly zero
      run_mul('0, Y0, M0, 0, s);
      check(s == '0, "R7 x zero", 512'(s), 512'(0));
      run_mul(X0, '0, M0, 0, s);
      check(s == '0, "R7 y zero", 512'(s), 512'(0));

      // R6: start during a run changes neither result nor latency
      run_mul(X0, Y0, M0, 0, s2);
      run_mul(X0, Y0, M0, 100, s);
      check(s == s2, "R6 result unchanged", 512'(s), 512'(s2));
      check(cong_ok(s, X0, Y0, M0), "R6 congruence", 512'(s), 512'(M0));

      // R5: done and result held while no start arrives
      repeat (25) @(negedge clk);
      check(done == 1'b1, "R5 done held", 512'(done), 512'(1));
      read_s(s2);
      check(s2 == s, "R5 result held", 512'(s2), 512'(s));

      // R9: address beyond the result words reads zero
      if (NW < (1 << WIW)) begin
         s_raddr = WIW'(NW);
         #0.2;
         check(s_rdata == '0, "R9 out of range", 512'(s_rdata), 512'(0));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule